// File: doc/BRIEF.md
# Transmit Jabber Guard

This block watches a transmitter's activity line and stops a transmitter that stays on the bus for too long. A timeout code sets the longest allowed run of uninterrupted transmission, counted in fixed time units. When a run reaches that limit, the block trips. It raises an inhibit output that forces the transmitter off and a carrier-detect style fault output. Both stay high for a fixed silence period, then both are released together.

All timing comes from an external timebase strobe, `tick_in`. The parameter `UNIT_TICKS` sets how many strobes make one timeout unit, which is 2.048 ms in the field. The parameter `SILENCE_TICKS` sets how many strobes make the lockout, which is 3 s in the field. A simulation can shrink both values. A code of zero turns the guard off. The code is captured only while the guard is idle, so a transmission in progress always runs against the limit it started with.

Top module: `jabber_guard`

## Requirements
- R1: With a timeout code of 0, `tx_inhibit` and `fault_cd` stay low whatever `tx_active` and `tick_in` do.
- R2: With a nonzero code N, the guard starts counting in the cycle after it sees `tx_active` high while idle. It trips on the tick edge that completes N×UNIT_TICKS ticks sampled while `tx_active` stays high.
- R3: On a trip, `tx_inhibit` and `fault_cd` both go high at the same clock edge.
- R4: Once tripped, both outputs stay high for exactly SILENCE_TICKS ticks. They fall together at the edge that samples the last of those ticks.
- R5: If `tx_active` goes low before the limit is reached, the guard returns to idle and the accumulated run time is discarded.
- R6: During the lockout, `tx_active` has no effect: the lockout length and the outputs do not change.
- R7: The guard samples `timeout_code` only while idle. A change during a run or a lockout does not alter the limit of that run.
- R8: After a synchronous reset, the guard is idle and both outputs are low.
- R9: If `tx_active` is still high when a lockout ends, a new run starts from zero. It needs another full N×UNIT_TICKS ticks to trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Timebase strobe, one cycle per tick |
| tx_active | input | 1 | High while the transmitter is driving the bus |
| timeout_code | input | CODE_W | Run limit in units of UNIT_TICKS ticks; 0 disables the guard |
| tx_inhibit | output | 1 | High while transmission is forced off |
| fault_cd | output | 1 | Fault indication, high for the whole lockout |

## Verification
The assertions check on every cycle that:
- a zero code keeps the guard idle;
- a trip comes only from a run whose unit count has completed;
- the outputs are released only by the end of the silence count;
- a lockout cannot be left early;
- a dropped `tx_active` ends a run at once;
- the captured code holds still outside idle.

The bench's scenarios are what show the exact trip and release edges in tick units, and that counting restarts from zero after a break or after a lockout. They also show that a code change in the middle of a run leaves that run's limit unchanged.

// File: rtl/jab_pkg.sv
package jab_pkg;
  typedef enum logic [1:0] {
    JG_IDLE = 2'd0,
    JG_RUN  = 2'd1,
    JG_LOCK = 2'd2
  } jg_state_t;
endpackage

// File: rtl/jab_span_counter.sv
// Generic tick counter: counts step strobes and reports the strobe that
// completes 'limit' of them, then wraps to zero. A zero limit never hits.
module jab_span_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_comb begin
    hit = step && !clr && (limit != '0) && (cnt_q == limit - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (hit) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Count never reaches or passes the limit it is compared against (R2)
  assert_count_below_limit_R2: assert property (@(posedge clk) disable iff (rst)
    (limit != '0 && cnt_q != '0) |-> (cnt_q < limit));
endmodule

// File: rtl/jab_ctrl.sv
// Run / lockout sequencer with registered fault outputs.
module jab_ctrl
  import jab_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_active,
  input  logic [CODE_W-1:0] timeout_code,
  input  logic              unit_trip,
  input  logic              quiet_done,
  output logic [CODE_W-1:0] code_q,
  output logic              run_ok,
  output logic              lock_on,
  output logic              inhibit_q,
  output logic              fault_q
);
  jg_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      JG_IDLE: if (tx_active && timeout_code != '0) state_d = JG_RUN;
      JG_RUN: begin
        if (!tx_active)     state_d = JG_IDLE;
        else if (unit_trip) state_d = JG_LOCK;
      end
      JG_LOCK: if (quiet_done) state_d = JG_IDLE;
      default: state_d = JG_IDLE;
    endcase
  end

  always_comb begin
    run_ok  = (state_q == JG_RUN) && tx_active;
    lock_on = (state_q == JG_LOCK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= JG_IDLE;
      code_q    <= '0;
      inhibit_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (state_q == JG_IDLE) code_q <= timeout_code;
      inhibit_q <= (state_d == JG_LOCK);
      fault_q   <= (state_d == JG_LOCK);
    end
  end

  // Zero code keeps the guard idle (R1)
  assert_zero_code_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == JG_IDLE && timeout_code == '0) |=> (state_q == JG_IDLE));
  // A trip only follows a completed run (R3)
  assert_trip_from_run_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> ($past(state_q) == JG_RUN && $past(unit_trip)));
  // Release only when the silence count completes (R4)
  assert_release_on_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_q) |-> $past(quiet_done));
  // A dropped transmit ends the run (R5)
  assert_break_ends_run_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == JG_RUN && !tx_active) |=> (state_q == JG_IDLE));
  // Lockout cannot be left early (R6)
  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == JG_LOCK && !quiet_done) |=> (inhibit_q && fault_q));
  // Captured code frozen outside idle (R7)
  assert_code_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q != JG_IDLE) |=> $stable(code_q));
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
  import jab_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int UNIT_TICKS    = 2048,
  parameter int SILENCE_TICKS = 3000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              tx_active,
  input  logic [CODE_W-1:0] timeout_code,
  output logic              tx_inhibit,
  output logic              fault_cd
);
  localparam int UNIT_W = $clog2(UNIT_TICKS + 1);
  localparam int SIL_W  = $clog2(SILENCE_TICKS + 1);
  localparam logic [UNIT_W-1:0] UNIT_LIM = UNIT_W'(UNIT_TICKS);
  localparam logic [SIL_W-1:0]  SIL_LIM  = SIL_W'(SILENCE_TICKS);

  logic [CODE_W-1:0] code_q;
  logic run_ok, lock_on, unit_stb, unit_trip, quiet_done;
  logic inhibit_q, fault_q;

  jab_span_counter #(.W(UNIT_W)) u_unit_pre (
    .clk(clk), .rst(rst), .clr(!run_ok), .step(tick_in && run_ok),
    .limit(UNIT_LIM), .hit(unit_stb)
  );

  jab_span_counter #(.W(CODE_W)) u_unit_cnt (
    .clk(clk), .rst(rst), .clr(!run_ok), .step(unit_stb),
    .limit(code_q), .hit(unit_trip)
  );

  jab_span_counter #(.W(SIL_W)) u_quiet (
    .clk(clk), .rst(rst), .clr(!lock_on), .step(tick_in && lock_on),
    .limit(SIL_LIM), .hit(quiet_done)
  );

  jab_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst(rst), .tx_active(tx_active), .timeout_code(timeout_code),
    .unit_trip(unit_trip), .quiet_done(quiet_done), .code_q(code_q),
    .run_ok(run_ok), .lock_on(lock_on), .inhibit_q(inhibit_q), .fault_q(fault_q)
  );

  assign tx_inhibit = inhibit_q;
  assign fault_cd   = fault_q;

  // Both outputs move together (R3)
  assert_outputs_paired_R3: assert property (@(posedge clk) disable iff (rst)
    tx_inhibit == fault_cd);
endmodule

// File: tb/test_jabber_guard.sv
module test_jabber_guard;
  localparam int UNIT = 4;
  localparam int SIL  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_in = 1'b0;
  logic tx_active = 1'b0;
  logic [7:0] timeout_code = 8'd0;
  logic tx_inhibit, fault_cd;

  always #2 clk = ~clk;

  jabber_guard #(.CODE_W(8), .UNIT_TICKS(UNIT), .SILENCE_TICKS(SIL)) i_jabber_guard (
    .clk(clk), .rst(rst), .tick_in(tick_in), .tx_active(tx_active),
    .timeout_code(timeout_code), .tx_inhibit(tx_inhibit), .fault_cd(fault_cd)
  );

  int total = 0;
  int bad = 0;
  string req = "R8";
  bit live = 0;
  int tick_per = 2;
  int tick_ph = 0;
  int cyc = 0;
  int trips = 0;

  // behavioural reference: 0 idle, 1 run, 2 lockout
  int m_st = 0;
  int m_acc = 0;
  int m_sil = 0;
  int m_code = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_acc = 0; m_sil = 0; m_code = 0;
    end else begin
      case (m_st)
        0: begin
          m_code = timeout_code;
          if (tx_active && timeout_code != 0) begin m_st = 1; m_acc = 0; end
        end
        1: begin
          if (!tx_active) m_st = 0;
          else if (tick_in) begin
            m_acc++;
            if (m_acc == m_code * UNIT) begin m_st = 2; m_sil = 0; trips++; end
          end
        end
        default: begin
          if (tick_in) begin
            m_sil++;
            if (m_sil == SIL) m_st = 0;
          end
        end
      endcase
    end
  end

  task automatic check(input string r, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (live) begin
      check(req, tx_inhibit, m_st == 2, "tx_inhibit");
      check(req, fault_cd, m_st == 2, "fault_cd");
    end
    tick_ph = (tick_ph + 1) % tick_per;
    tick_in = (tick_ph == 0);
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    live = 1;
    @(negedge clk);
    req = "R8";
    check("R8", tx_inhibit, 1'b0, "reset inhibit");
    check("R8", fault_cd, 1'b0, "reset fault");

    // R1: zero code never trips
    req = "R1";
    timeout_code = 8'd0; tx_active = 1'b1;
    run(300);
    check("R1", tx_inhibit, 1'b0, "disabled inhibit");
    tx_active = 1'b0; run(5);

    // R2 R3 R6 R9: trip, lockout ignoring tx, re-run
    req = "R2";
    timeout_code = 8'd3; run(2);
    tx_active = 1'b1;
    run(20);
    check("R2", tx_inhibit, 1'b0, "before limit");
    run(10);
    req = "R6";
    check("R3", fault_cd, 1'b1, "tripped fault");
    tx_active = 1'b0; run(7); tx_active = 1'b1; run(20);
    req = "R4"; run(60);
    req = "R9"; run(40);
    check("R9", trips >= 2 ? 1'b1 : 1'b0, 1'b1, "second trip");
    tx_active = 1'b0; run(100);

    // R5: short bursts never accumulate
    req = "R5";
    timeout_code = 8'd2; tick_per = 1;
    for (int k = 0; k < 6; k++) begin
      tx_active = 1'b1; run(6);
      tx_active = 1'b0; run(2);
    end
    check("R5", tx_inhibit, 1'b0, "bursts");

    // R7: code change during a run
    req = "R7";
    timeout_code = 8'd5; run(2);
    tx_active = 1'b1; run(4);
    timeout_code = 8'd1; run(10);
    check("R7", tx_inhibit, 1'b0, "old limit kept");
    run(15);
    tx_active = 1'b0; run(50);

    // boundary codes
    req = "R2";
    timeout_code = 8'd1; tick_per = 3; run(2);
    tx_active = 1'b1; run(200);
    tx_active = 1'b0; run(150);
    timeout_code = 8'd255; tick_per = 1; run(2);
    tx_active = 1'b1; run(1060);
    check("R2", tx_inhibit, 1'b1, "max code tripped");
    tx_active = 1'b0; run(60);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule